// File: doc/BRIEF.md
# Filtered Quadrature Decoder Front End

This block is the input stage of one encoder axis. It takes the raw A, B and active-low index pins, removes short glitches with a sampled level filter, and turns the cleaned signals into single-cycle count-up and count-down strobes for a downstream position counter. The filter samples on a tick that runs at the core clock rate or at half of it. An input level is accepted only after it has held steady for two tick periods.

The quadrature decoder is a four-state machine that tracks the cleaned (A,B) phase: `PH_00`, `PH_10`, `PH_11`, `PH_01`. Each clock it compares the tracked phase with the new cleaned phase and classifies the move as one of four transitions. A *forward step* is a move in the sequence 00→10→11→01→00, where A leads. A *reverse step* is a move the other way. A *skip* is a diagonal jump. A *hold* means no change. The resolution setting decides which steps produce a strobe. In clock/direction mode the filter is bypassed: each rising edge of A counts, and the level of B gives the direction.

The index input yields a one-cycle strobe. In asynchronous form the strobe comes from the synchronised falling pin edge. In synchronous form it comes from the filtered level, qualified by A and B being equal. The filter tick comes from a two-state generator (`TK_FIRE`, `TK_HOLD`). A count-clock output pulses alongside every count strobe.

Top module: `qdf_front`

## Requirements
- R1: During and after reset, with A=B=0 and the index pin high, all four outputs are 0.
- R2: `mode_sel` encodes 2'b00 clock/direction, 2'b01 x1, 2'b10 x2, 2'b11 x4. In the quadrature modes, A leading B (phase order 00→10→11→01) counts up.
- R3: In x4, every forward step gives one up strobe and every reverse step gives one down strobe, so there are four counts per cycle.
- R4: In x2, only steps in which A changes give a count, so there are two per cycle. Forward gives up and reverse gives down.
- R5: In x1, an up strobe comes only on the step 00→10 and a down strobe only on the step 10→00, so there is one count per cycle.
- R6: In clock/direction mode, each rising edge of A gives one up strobe when B is high and one down strobe when B is low. The filter is bypassed, so a one-cycle pulse on A counts.
- R7: A filtered level changes only on a filter tick, after the raw level has been seen at three consecutive ticks. With ticks every clock, a 2-cycle pulse is dropped and a 4-cycle pulse passes.
- R8: With `div2_en`=1, ticks come on alternate clocks only. A 4-cycle pulse is dropped and a 10-cycle pulse passes.
- R9: A skip transition (A and B changing together) gives no count.
- R10: With synchronous index off, or in clock/direction mode whatever `idx_sync_en` says, each falling edge of `in_idx_n` gives one `idx_strobe`, in any phase, even for a one-cycle pulse.
- R11: In a quadrature mode with `idx_sync_en`=1, `idx_strobe` fires once when the filtered index becomes active while filtered A equals filtered B. It does not fire while A differs from B, and it does not fire for a pulse that the filter drops.
- R12: `cnt_clk_o` is high exactly in the cycles in which `cnt_up` or `cnt_dn` is high.
- R13: `cnt_up` and `cnt_dn` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also the source of the filter tick |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Decode mode (see R2) |
| div2_en | input | 1 | 1: filter tick on alternate clocks |
| idx_sync_en | input | 1 | 1: synchronous, quadrant-gated index |
| in_a | input | 1 | Raw A input |
| in_b | input | 1 | Raw B input |
| in_idx_n | input | 1 | Raw index input, active low |
| cnt_up | output | 1 | One-cycle up-count strobe |
| cnt_dn | output | 1 | One-cycle down-count strobe |
| cnt_clk_o | output | 1 | Count clock; pulses with every count |
| idx_strobe | output | 1 | One-cycle index event |

## Verification
The properties assume that the mode and filter-rate controls change only while the inputs are quiet. They also assume that real quadrature steps are held for at least three filter ticks, which means six clocks when `div2_en`=1. The stimulus drives every input on the falling clock edge and holds each intended phase for eight clocks. Controls are switched only after the inputs have settled. Deliberately short pulses and simultaneous A/B changes are used only where a requirement says they must be dropped or ignored.

// File: rtl/qdf_pkg.sv
package qdf_pkg;

    typedef enum logic [1:0] {
        MODE_CLKDIR = 2'b00,
        MODE_X1     = 2'b01,
        MODE_X2     = 2'b10,
        MODE_X4     = 2'b11
    } qmode_e;

    typedef enum logic [1:0] {
        PH_00,
        PH_10,
        PH_11,
        PH_01
    } phase_e;

    typedef enum logic {
        TK_FIRE,
        TK_HOLD
    } tick_st_e;

endpackage

// File: rtl/qdf_tick_gen.sv
module qdf_tick_gen
    import qdf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic div2_en,
    output logic tick
);

    tick_st_e st_q, st_d;

    always_comb begin
        st_d = TK_FIRE;
        unique case (st_q)
            TK_FIRE: st_d = div2_en ? TK_HOLD : TK_FIRE;
            TK_HOLD: st_d = TK_FIRE;
            default: st_d = TK_FIRE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TK_FIRE;
        else        st_q <= st_d;
    end

    always_comb tick = (st_q == TK_FIRE);

    // R8: with halving on, two ticks are never back to back
    p_div2_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div2_en && $past(div2_en) && tick) |-> !$past(tick));

endmodule

// File: rtl/qdf_level_filter.sv
module qdf_level_filter #(
    parameter int   FILT_LEN = 2,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic level
);

    logic [FILT_LEN-1:0] hist_q;
    logic                all_hi, all_lo;

    always_comb begin
        all_hi = (&hist_q) & raw;
        all_lo = ~(|hist_q) & ~raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= {FILT_LEN{RST_VAL}};
            level  <= RST_VAL;
        end else if (tick) begin
            hist_q <= {hist_q[FILT_LEN-2:0], raw};
            if (all_hi || all_lo) level <= raw;
        end
    end

    // R7: the accepted level moves only on a tick and only towards the sampled value
    p_change_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(tick) && ($past(raw) == level)));

endmodule

// File: rtl/qdf_quad_fsm.sv
module qdf_quad_fsm
    import qdf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  qmode_e mode,
    input  logic   fa,
    input  logic   fb,
    output logic   q_up,
    output logic   q_dn
);

    phase_e ph_q, ph_d;
    logic   fwd, rev, a_was, a_moved;
    logic   up_d, dn_d;

    always_comb begin
        unique case ({fa, fb})
            2'b00:   ph_d = PH_00;
            2'b10:   ph_d = PH_10;
            2'b11:   ph_d = PH_11;
            default: ph_d = PH_01;
        endcase
    end

    // transition classification: forward, reverse, skip or hold
    always_comb begin
        fwd   = 1'b0;
        rev   = 1'b0;
        a_was = 1'b0;
        unique case (ph_q)
            PH_00: begin fwd = (ph_d == PH_10); rev = (ph_d == PH_01); a_was = 1'b0; end
            PH_10: begin fwd = (ph_d == PH_11); rev = (ph_d == PH_00); a_was = 1'b1; end
            PH_11: begin fwd = (ph_d == PH_01); rev = (ph_d == PH_10); a_was = 1'b1; end
            PH_01: begin fwd = (ph_d == PH_00); rev = (ph_d == PH_11); a_was = 1'b0; end
            default: begin fwd = 1'b0; rev = 1'b0; a_was = 1'b0; end
        endcase
        a_moved = (a_was != fa);
    end

    always_comb begin
        up_d = 1'b0;
        dn_d = 1'b0;
        unique case (mode)
            MODE_X4: begin up_d = fwd; dn_d = rev; end
            MODE_X2: begin up_d = fwd & a_moved; dn_d = rev & a_moved; end
            MODE_X1: begin
                up_d = (ph_q == PH_00) && (ph_d == PH_10);
                dn_d = (ph_q == PH_10) && (ph_d == PH_00);
            end
            default: begin up_d = 1'b0; dn_d = 1'b0; end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_00;
        else        ph_q <= ph_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_up <= 1'b0;
            q_dn <= 1'b0;
        end else begin
            q_up <= up_d;
            q_dn <= dn_d;
        end
    end

    // R5: in x1 an up count only lands on entering PH_10 from PH_00
    p_x1_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_X1 && q_up) |-> (ph_q == PH_10 && $past(ph_q) == PH_00));

    // R9: a diagonal jump never counts
    p_skip_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(ph_q) == PH_00) && (ph_q == PH_11)) ||
         (($past(ph_q) == PH_11) && (ph_q == PH_00)) ||
         (($past(ph_q) == PH_10) && (ph_q == PH_01)) ||
         (($past(ph_q) == PH_01) && (ph_q == PH_10))) |-> (!q_up && !q_dn));

endmodule

// File: rtl/qdf_front.sv
module qdf_front
    import qdf_pkg::*;
#(
    parameter int FILT_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       div2_en,
    input  logic       idx_sync_en,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       in_idx_n,
    output logic       cnt_up,
    output logic       cnt_dn,
    output logic       cnt_clk_o,
    output logic       idx_strobe
);

    localparam int N_IN  = 3;
    localparam int BIT_A = 0;
    localparam int BIT_B = 1;
    localparam int BIT_I = 2;

    qmode_e          mode;
    logic [N_IN-1:0] raw_v, s1_q, s2_q, s3_q, flt_v;
    logic            tick;
    logic            q_up, q_dn;
    logic            cd_up_q, cd_dn_q, a_rise;
    logic            sync_eff, sync_qual, sync_prev_q, idx_hit, idx_q;

    always_comb begin
        mode  = qmode_e'(mode_sel);
        raw_v = {~in_idx_n, in_b, in_a};
    end

    // two-flop synchroniser plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= raw_v;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    qdf_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div2_en (div2_en),
        .tick    (tick)
    );

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_filt
        qdf_level_filter #(
            .FILT_LEN (FILT_LEN),
            .RST_VAL  (1'b0)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .raw   (s2_q[gi]),
            .level (flt_v[gi])
        );
    end

    qdf_quad_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .fa    (flt_v[BIT_A]),
        .fb    (flt_v[BIT_B]),
        .q_up  (q_up),
        .q_dn  (q_dn)
    );

    // clock/direction path, filter bypassed
    always_comb a_rise = s2_q[BIT_A] & ~s3_q[BIT_A];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_up_q <= 1'b0;
            cd_dn_q <= 1'b0;
        end else begin
            cd_up_q <= a_rise &  s2_q[BIT_B];
            cd_dn_q <= a_rise & ~s2_q[BIT_B];
        end
    end

    // index path
    always_comb begin
        sync_eff  = idx_sync_en && (mode != MODE_CLKDIR);
        sync_qual = flt_v[BIT_I] && (flt_v[BIT_A] == flt_v[BIT_B]);
        idx_hit   = sync_eff ? (sync_qual & ~sync_prev_q)
                             : (s2_q[BIT_I] & ~s3_q[BIT_I]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_prev_q <= 1'b0;
            idx_q       <= 1'b0;
        end else begin
            sync_prev_q <= sync_qual;
            idx_q       <= idx_hit;
        end
    end

    always_comb begin
        cnt_up     = (mode == MODE_CLKDIR) ? cd_up_q : q_up;
        cnt_dn     = (mode == MODE_CLKDIR) ? cd_dn_q : q_dn;
        cnt_clk_o  = cnt_up | cnt_dn;
        idx_strobe = idx_q;
    end

    // R13: one direction at a time
    p_one_dir_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up && cnt_dn));

    // R11: a synchronous index only fires in an equal-level quadrant
    p_sync_quadrant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_strobe && $past(idx_sync_en) && ($past(mode) != MODE_CLKDIR))
            |-> ($past(flt_v[BIT_A]) == $past(flt_v[BIT_B])));

    // R6: a clock/direction count follows a synchronised rising edge of A
    p_cd_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_up_q || cd_dn_q) |-> ($past(s2_q[BIT_A]) && !$past(s3_q[BIT_A])));

endmodule

// File: tb/test_qdf_front.sv
module test_qdf_front;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic       div2_en, idx_sync_en, in_a, in_b, in_idx_n;
    logic       cnt_up, cnt_dn, cnt_clk_o, idx_strobe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qdf_front i_qdf_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .div2_en     (div2_en),
        .idx_sync_en (idx_sync_en),
        .in_a        (in_a),
        .in_b        (in_b),
        .in_idx_n    (in_idx_n),
        .cnt_up      (cnt_up),
        .cnt_dn      (cnt_dn),
        .cnt_clk_o   (cnt_clk_o),
        .idx_strobe  (idx_strobe)
    );

    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;
    byte   exp_q[$];
    int    idx_pend = 0;
    string cur_req = "R1";
    bit    pa = 1'b0, pb = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int gidx(bit a, bit b);
        return a ? (b ? 2 : 1) : (b ? 3 : 0);
    endfunction

    // expected count per requirement: 0 none, 1 up, 2 down
    function automatic int exp_step(logic [1:0] m, bit oa, bit ob, bit na, bit nb);
        int d, pi, ni;
        pi = gidx(oa, ob);
        ni = gidx(na, nb);
        d  = (ni - pi + 4) % 4;
        case (m)
            2'b11: return (d == 1) ? 1 : (d == 3) ? 2 : 0;
            2'b10: if (oa != na) return (d == 1) ? 1 : (d == 3) ? 2 : 0;
                   else return 0;
            2'b01: return (pi == 0 && ni == 1) ? 1 : (pi == 1 && ni == 0) ? 2 : 0;
            default: return 0;
        endcase
    endfunction

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && !done) begin
                if (cnt_up || cnt_dn) begin
                    byte got, e;
                    got = cnt_up ? "U" : "D";
                    chk(!(cnt_up && cnt_dn), "R13", "both strobes", 1, 0);
                    chk(cnt_clk_o === 1'b1, "R12", "count clock with strobe", int'(cnt_clk_o), 1);
                    if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected count", int'(got), 0);
                    else begin
                        e = exp_q.pop_front();
                        chk(got == e, cur_req, "count kind", int'(got), int'(e));
                    end
                end else if (cnt_clk_o) begin
                    chk(1'b0, "R12", "count clock without strobe", 1, 0);
                end
                if (idx_strobe) begin
                    if (idx_pend > 0) begin
                        idx_pend--;
                        chk(1'b1, cur_req, "index", 1, 1);
                    end else chk(1'b0, cur_req, "unexpected index", 1, 0);
                end
            end
        end
    end

    task automatic qstep(bit na, bit nb, int hold);
        int r;
        r = exp_step(mode_sel, pa, pb, na, nb);
        if (r == 1) exp_q.push_back("U");
        if (r == 2) exp_q.push_back("D");
        @(negedge clk);
        in_a = na; in_b = nb; pa = na; pb = nb;
        repeat (hold) @(negedge clk);
    endtask

    task automatic pulse_a(int len);
        @(negedge clk);
        in_a = 1'b1;
        repeat (len) @(negedge clk);
        in_a = 1'b0;
    endtask

    task automatic settle(string req);
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0, req, "counts missing", exp_q.size(), 0);
        chk(idx_pend == 0, req, "index missing", idx_pend, 0);
        exp_q.delete();
        idx_pend = 0;
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode_sel = m;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; mode_sel = 2'b11; div2_en = 1'b0; idx_sync_en = 1'b0;
        in_a = 1'b0; in_b = 1'b0; in_idx_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(cnt_up == 1'b0, "R1", "cnt_up in reset", int'(cnt_up), 0);
        chk(cnt_dn == 1'b0, "R1", "cnt_dn in reset", int'(cnt_dn), 0);
        chk(cnt_clk_o == 1'b0, "R1", "cnt_clk_o in reset", int'(cnt_clk_o), 0);
        chk(idx_strobe == 1'b0, "R1", "idx_strobe in reset", int'(idx_strobe), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk((cnt_up | cnt_dn | cnt_clk_o | idx_strobe) == 1'b0, "R1", "outputs after reset", 1, 0);

        // x4 forward (direction) and reverse
        cur_req = "R2";
        qstep(1,0,8); qstep(1,1,8); qstep(0,1,8); qstep(0,0,8);
        settle("R2");
        cur_req = "R3";
        qstep(0,1,8); qstep(1,1,8); qstep(1,0,8); qstep(0,0,8);
        settle("R3");

        // x2
        set_mode(2'b10); cur_req = "R4";
        qstep(1,0,8); qstep(1,1,8); qstep(0,1,8); qstep(0,0,8);
        qstep(0,1,8); qstep(1,1,8); qstep(1,0,8); qstep(0,0,8);
        settle("R4");

        // x1
        set_mode(2'b01); cur_req = "R5";
        qstep(1,0,8); qstep(1,1,8); qstep(0,1,8); qstep(0,0,8);
        qstep(0,1,8); qstep(1,1,8); qstep(1,0,8); qstep(0,0,8);
        settle("R5");

        // skips
        set_mode(2'b11); cur_req = "R9";
        qstep(1,1,8); qstep(0,0,8); qstep(1,0,8); qstep(0,1,8); qstep(0,0,8);
        settle("R9");

        // filter at full tick rate
        cur_req = "R7";
        pulse_a(2);
        settle("R7");
        exp_q.push_back("U"); exp_q.push_back("D");
        pulse_a(4);
        settle("R7");

        // filter at half tick rate
        @(negedge clk); div2_en = 1'b1; repeat (4) @(negedge clk);
        cur_req = "R8";
        pulse_a(4);
        settle("R8");
        exp_q.push_back("U"); exp_q.push_back("D");
        pulse_a(10);
        settle("R8");
        qstep(1,0,8); qstep(1,1,8); qstep(0,1,8); qstep(0,0,8);
        settle("R8");
        @(negedge clk); div2_en = 1'b0; repeat (4) @(negedge clk);

        // clock/direction
        set_mode(2'b00); cur_req = "R6";
        @(negedge clk); in_b = 1'b1; repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            exp_q.push_back("U");
            in_a = 1'b1; @(negedge clk);
            in_a = 1'b0; @(negedge clk);
        end
        in_b = 1'b0; repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            exp_q.push_back("D");
            in_a = 1'b1; repeat (2) @(negedge clk);
            in_a = 1'b0; repeat (2) @(negedge clk);
        end
        settle("R6");

        // asynchronous index
        set_mode(2'b11); cur_req = "R10";
        qstep(1,0,8);
        idx_pend++;
        in_idx_n = 1'b0; @(negedge clk); in_idx_n = 1'b1;
        settle("R10");
        qstep(0,0,8);
        settle("R10");
        set_mode(2'b00);
        @(negedge clk); idx_sync_en = 1'b1; repeat (3) @(negedge clk);
        idx_pend++;
        in_idx_n = 1'b0; @(negedge clk); in_idx_n = 1'b1;
        settle("R10");

        // synchronous index
        set_mode(2'b11); cur_req = "R11";
        in_idx_n = 1'b0; @(negedge clk); in_idx_n = 1'b1;
        settle("R11");
        qstep(1,0,8);
        in_idx_n = 1'b0; repeat (10) @(negedge clk); in_idx_n = 1'b1;
        settle("R11");
        qstep(0,0,8);
        idx_pend++;
        in_idx_n = 1'b0; repeat (10) @(negedge clk); in_idx_n = 1'b1;
        settle("R11");

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, 1, 0);
            summary();
            $finish;
        end
    end

endmodule